// File: doc/BRIEF.md
# Four-Lane Immediate Shuffle Unit

This block rearranges 32-bit lanes of two 128-bit vectors under an 8-bit immediate. Each vector holds four lanes. The immediate packs four 2-bit lane selectors, one for each result lane. The two lower result lanes are taken from the destination operand. The two upper result lanes are taken from the source operand. Lanes are copied as raw bit patterns, so any 32-bit value comes through unchanged, whatever it would mean as a number.

A caller presents both operands and the immediate together with a valid strobe. One clock later the rearranged vector appears on a registered output, with an output valid that marks it. In cycles with no valid input the output register keeps its last value.

Lane k of a vector occupies bits [32k+31:32k]. Passing the same vector as both operands turns the unit into a single-vector permute.

Top module: `lane_shuffle_unit`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_vec is all zeros.
- R2: One clock after an accepted input, result lane 0 (bits [31:0]) equals destination lane ctrl_imm[1:0].
- R3: One clock after an accepted input, result lane 1 (bits [63:32]) equals destination lane ctrl_imm[3:2].
- R4: One clock after an accepted input, result lane 2 (bits [95:64]) equals source lane ctrl_imm[5:4].
- R5: One clock after an accepted input, result lane 3 (bits [127:96]) equals source lane ctrl_imm[7:6].
- R6: out_valid in each cycle equals in_valid of the previous clock edge. Back-to-back inputs give back-to-back results.
- R7: When in_valid is low at a clock edge, out_vec keeps its value, whatever the operands and immediate are.
- R8: With the same vector on both operands and ctrl_imm = 8'hC9 (selectors 3,0,2,1 from high lane to low), the result lanes from low to high are input lanes 1,2,0,3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands and immediate are valid this cycle |
| dst_vec | input | 128 | Destination operand; feeds result lanes 0 and 1 |
| src_vec | input | 128 | Source operand; feeds result lanes 2 and 3 |
| ctrl_imm | input | 8 | Four 2-bit lane selectors, result lane k uses bits [2k+1:2k] |
| out_valid | output | 1 | out_vec holds a fresh result |
| out_vec | output | 128 | Registered shuffled vector |

## Verification
Two things can happen in the same cycle: the result register shows the previous answer, and it is loaded with the next one. Valid inputs are sent back-to-back and then mixed at random with idle cycles that carry junk operands. A reference model built from queues and integer lane indexes predicts each clock's output and checks that loads and holds alternate correctly. Immediates in which several selectors pick the same lane, and the same vector on both operands, show that the two halves draw from their own operand.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int unsigned LANE_W_DEF = 32;
  localparam int unsigned LANES_DEF  = 4;

  // Width of one lane selector for a given lane count
  function automatic int unsigned sel_width(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/shuf_lane_mux.sv
// Picks one lane of a packed vector under a binary selector.
module shuf_lane_mux #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [LANES*LANE_W-1:0] vec_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [LANE_W-1:0]       lane_o
);
  always_comb begin
    lane_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (sel_i == SEL_W'(k)) lane_o = vec_i[k*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/shuf_out_reg.sv
// Result register with explicit clock enable and a valid flag.
module shuf_out_reg #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] data_nxt;
  logic         valid_nxt;

  always_comb begin
    data_nxt  = data_o;
    valid_nxt = load_i;
    if (load_i) data_nxt = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      data_o  <= data_nxt;
      valid_o <= valid_nxt;
    end
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit #(
  parameter int unsigned LANE_W = shuf_pkg::LANE_W_DEF,
  parameter int unsigned LANES  = shuf_pkg::LANES_DEF,
  localparam int unsigned SEL_W = shuf_pkg::sel_width(LANES),
  localparam int unsigned VEC_W = LANE_W * LANES,
  localparam int unsigned IMM_W = SEL_W * LANES,
  localparam int unsigned LOW_LANES = LANES / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] dst_vec,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [IMM_W-1:0] ctrl_imm,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_vec
);
  logic [VEC_W-1:0] shuf_vec;

  // Lower half of the result draws from dst, upper half from src
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [VEC_W-1:0] operand;
    if (g < LOW_LANES) begin : g_low
      assign operand = dst_vec;
    end else begin : g_high
      assign operand = src_vec;
    end
    shuf_lane_mux #(
      .LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)
    ) u_mux (
      .vec_i (operand),
      .sel_i (ctrl_imm[g*SEL_W +: SEL_W]),
      .lane_o(shuf_vec[g*LANE_W +: LANE_W])
    );
  end

  shuf_out_reg #(.W(VEC_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (in_valid),
    .data_i (shuf_vec),
    .valid_o(out_valid),
    .data_o (out_vec)
  );
endmodule

// File: rtl/shuf_chk.sv
module shuf_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [127:0] dst_vec,
  input logic [127:0] src_vec,
  input logic [7:0]   ctrl_imm,
  input logic         out_valid,
  input logic [127:0] out_vec
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (out_valid == 1'b0 && out_vec == '0)
        else $error("reset state wrong");
    end
  end

  // R2
  lane0_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vec[31:0] == $past(dst_vec[ctrl_imm[1:0]*32 +: 32]));

  // R3
  lane1_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vec[63:32] == $past(dst_vec[ctrl_imm[3:2]*32 +: 32]));

  // R4
  lane2_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vec[95:64] == $past(src_vec[ctrl_imm[5:4]*32 +: 32]));

  // R5
  lane3_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_vec[127:96] == $past(src_vec[ctrl_imm[7:6]*32 +: 32]));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));
endmodule

bind lane_shuffle_unit shuf_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .dst_vec  (dst_vec),
  .src_vec  (src_vec),
  .ctrl_imm (ctrl_imm),
  .out_valid(out_valid),
  .out_vec  (out_vec)
);

// File: tb/sim_lane_shuffle_unit.sv
`timescale 1ns/1ps
module sim_lane_shuffle_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] dst_vec = '0;
  logic [127:0] src_vec = '0;
  logic [7:0]   ctrl_imm = '0;
  logic         out_valid;
  logic [127:0] out_vec;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;  // 50 MHz

  lane_shuffle_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .dst_vec(dst_vec), .src_vec(src_vec), .ctrl_imm(ctrl_imm),
    .out_valid(out_valid), .out_vec(out_vec)
  );

  // Reference model: a queue of predicted lanes, refilled each edge
  logic [31:0] exp_lane [$];
  logic        exp_valid = 1'b0;
  logic        last_was_idle = 1'b0;

  function automatic logic [31:0] pick(input logic [127:0] v, input int idx);
    return v[idx*32 +: 32];
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) exp_lane.push_back(32'h0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0;
      for (int k = 0; k < 4; k++) exp_lane[k] = 32'h0;
      last_was_idle <= 1'b0;
    end else begin
      exp_valid <= in_valid;
      last_was_idle <= !in_valid;
      if (in_valid) begin
        int s0, s1, s2, s3;
        s0 = int'(ctrl_imm[1:0]); s1 = int'(ctrl_imm[3:2]);
        s2 = int'(ctrl_imm[5:4]); s3 = int'(ctrl_imm[7:6]);
        exp_lane.delete();
        exp_lane.push_back(pick(dst_vec, s0));
        exp_lane.push_back(pick(dst_vec, s1));
        exp_lane.push_back(pick(src_vec, s2));
        exp_lane.push_back(pick(src_vec, s3));
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 1'b0, "R1 valid", {127'b0, out_valid}, 128'h0);
      check(out_vec == '0, "R1 data", out_vec, 128'h0);
    end else begin
      string tag;
      check(out_valid == exp_valid, "R6 valid", {127'b0, out_valid}, {127'b0, exp_valid});
      for (int k = 0; k < 4; k++) begin
        if (last_was_idle) tag = "R7 hold";
        else tag = (k == 0) ? "R2 lane0" : (k == 1) ? "R3 lane1" :
                   (k == 2) ? "R4 lane2" : "R5 lane3";
        check(out_vec[k*32 +: 32] == exp_lane[k], tag,
              {96'b0, out_vec[k*32 +: 32]}, {96'b0, exp_lane[k]});
      end
    end
  end

  task automatic drive(input bit v, input logic [127:0] d, input logic [127:0] s,
                       input logic [7:0] imm);
    @(negedge clk);
    #1;
    in_valid = v; dst_vec = d; src_vec = s; ctrl_imm = imm;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] same;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;

    // R2..R5: identity and reversal selectors
    drive(1, 128'h33333333_22222222_11111111_00000000,
             128'hBBBBBBBB_AAAAAAAA_99999999_88888888, 8'hE4);
    drive(1, 128'h33333333_22222222_11111111_00000000,
             128'hBBBBBBBB_AAAAAAAA_99999999_88888888, 8'h1B);
    // repeated selectors, raw NaN-like patterns
    drive(1, 128'h7FC00001_FFFFFFFF_80000000_7F800000,
             128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 8'h00);
    drive(1, 128'h7FC00001_FFFFFFFF_80000000_7F800000,
             128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 8'hFF);
    // R7: idle with junk inputs
    drive(0, rnd128(), rnd128(), 8'h5A);
    drive(0, rnd128(), rnd128(), 8'hA5);

    // R8: same vector on both sides, selectors 3,0,2,1
    same = 128'hD3D3D3D3_C2C2C2C2_B1B1B1B1_A0A0A0A0;
    drive(1, same, same, 8'hC9);
    drive(0, '0, '0, 8'h00);
    @(negedge clk);
    check(out_vec == 128'hD3D3D3D3_A0A0A0A0_C2C2C2C2_B1B1B1B1, "R8 permute",
          out_vec, 128'hD3D3D3D3_A0A0A0A0_C2C2C2C2_B1B1B1B1);

    // Back-to-back and mixed random traffic
    for (int i = 0; i < 400; i++)
      drive(($urandom % 4) != 0, rnd128(), rnd128(), 8'($urandom));
    drive(0, '0, '0, 8'h00);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule